// File: doc/BRIEF.md
# Periodic Direction-Code Trail Generator and Decoder

This block lays down and reads back a repeating six-bit binary trail that carries its own sense of direction. The generator side walks a six-state phase machine and puts one trail bit per clock on a serial output while its enable is high. The code is `100110`, or its bitwise complement `011001` when the polarity parameter selects the inverted trail. Six bits is the shortest period for which reading direction can be decoded. The decoder side accepts one serial bit per clock under a valid strobe and keeps the five most recent accepted bits.

Any five consecutive bits of the trail decide the direction in which they were read. None of the six cyclic five-bit windows read forward equals any of the six windows read backward. Once five bits have been accepted, the decoder reports whether its current window belongs to the forward set or the backward set. It raises an error flag when the window is in neither set, which marks a corrupted or foreign stream. The block does not recover the phase within the period.

The generator state machine has states PH0 to PH5, with the transitions PH0→PH1→PH2→PH3→PH4→PH5→PH0, taken on each enabled clock. A clock with the enable low holds the current state. The decoder state machine has two states. In FILL it counts accepted bits, and on the fifth accepted bit it moves FILL→LIVE. It stays in LIVE until reset, and reset returns both machines to PH0 and FILL.

Top module: `trail_dir_codec`

## Requirements
- R1: With INVERT=0 and `gen_en` held high after reset, `trail_out` carries 1,0,0,1,1,0 and repeats it with period 6. The first bit appears in the first enabled cycle after reset.
- R2: With INVERT=1, `trail_out` carries the complement 0,1,1,0,0,1. The decoder's forward set then holds the cyclic windows of 011001, and its backward set holds those of 100110.
- R3: While `gen_en` is low, `trail_out` is 0 and the phase holds, so the next enabled cycle emits the bit that would have come next.
- R4: `dir_valid` is 0 until five bits have been accepted with `in_valid` high since reset. Cycles with `in_valid` low neither shift the window nor count.
- R5: The window has the oldest accepted bit in bit 4 and the newest in bit 0. When `dir_valid` is 1 and the window is a forward window, `dir_forward` is 1 and `dir_err` is 0. For INVERT=0 the forward windows are 10011, 00110, 01101, 11010, 10100 and 01001.
- R6: When `dir_valid` is 1 and the window is a backward window, `dir_forward` is 0 and `dir_err` is 0. For INVERT=0 the backward windows are 01100, 11001, 10010, 00101, 01011 and 10110.
- R7: When `dir_valid` is 1 and the window is in neither set, `dir_err` is 1 and `dir_forward` is 0. `dir_err` is 0 whenever `dir_valid` is 0.
- R8: A synchronous active-high `rst` returns the phase to PH0 and the decoder to FILL with an empty count. In the cycle after reset, `dir_valid` is 0.
- R9: The decoder outputs reflect a bit accepted at a clock edge from that edge on. No further cycle of latency is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Generator advance enable |
| trail_out | output | 1 | Serial trail bit (0 while disabled) |
| in_valid | input | 1 | Decoder input strobe |
| in_bit | input | 1 | Decoder serial input bit |
| dir_valid | output | 1 | Five or more bits accepted since reset |
| dir_forward | output | 1 | Window read in the forward direction |
| dir_err | output | 1 | Window matches neither direction |

## Verification
The hardest situation to reach is a window that straddles a read reversal or a stall. One case is a window built partly from forward bits and partly from backward bits. Another is a window in which invalid cycles fall between accepted bits, so the strobe gaps must not leak into the window. The bench reaches these states in several ways: it feeds the generator's own output back through a gapped strobe, it switches abruptly to a hand-driven backward stream, and it injects constant and foreign patterns. It also drives an inverted-polarity instance with the same stimulus, so every window is classified under both code polarities.

// File: rtl/trail_pkg.sv
package trail_pkg;

    localparam int PERIOD = 6;
    localparam int WIN    = 5;
    localparam int PH_W   = $clog2(PERIOD);
    localparam int CNT_W  = $clog2(WIN + 1);
    localparam logic [PERIOD-1:0] BASE_CODE = 6'b100110;

    typedef enum logic [PH_W-1:0] {
        PH0 = 3'd0,
        PH1 = 3'd1,
        PH2 = 3'd2,
        PH3 = 3'd3,
        PH4 = 3'd4,
        PH5 = 3'd5
    } phase_e;

    typedef enum logic {
        DS_FILL = 1'b0,
        DS_LIVE = 1'b1
    } dec_state_e;

    // Trail bit at position idx (0 = first emitted), optionally complemented.
    function automatic logic code_bit(input bit inv, input int idx);
        return BASE_CODE[PERIOD-1-idx] ^ inv;
    endfunction

    // Cyclic window starting at position start; first bit read lands in the MSB.
    // rev selects the trail read in the opposite direction.
    function automatic logic [WIN-1:0] window_at(input bit inv, input bit rev,
                                                 input int start);
        logic [WIN-1:0] w;
        w = '0;
        for (int k = 0; k < WIN; k++) begin
            int i;
            int j;
            i = (start + k) % PERIOD;
            j = rev ? (PERIOD - 1 - i) : i;
            w[WIN-1-k] = code_bit(inv, j);
        end
        return w;
    endfunction

endpackage

// File: rtl/trail_gen.sv
module trail_gen
    import trail_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    output logic            bit_o,
    output logic [PH_W-1:0] phase_o
);

    phase_e ph_q;
    phase_e ph_d;
    logic   raw_bit;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH0;
        end else if (en) begin
            ph_q <= ph_d;
        end
    end

    // Next-state logic: wrap after the last phase
    always_comb begin
        ph_d = PH0;
        unique case (ph_q)
            PH0:     ph_d = PH1;
            PH1:     ph_d = PH2;
            PH2:     ph_d = PH3;
            PH3:     ph_d = PH4;
            PH4:     ph_d = PH5;
            PH5:     ph_d = PH0;
            default: ph_d = PH0;
        endcase
    end

    // Output logic
    always_comb begin
        raw_bit = 1'b0;
        unique case (ph_q)
            PH0:     raw_bit = code_bit(INVERT, 0);
            PH1:     raw_bit = code_bit(INVERT, 1);
            PH2:     raw_bit = code_bit(INVERT, 2);
            PH3:     raw_bit = code_bit(INVERT, 3);
            PH4:     raw_bit = code_bit(INVERT, 4);
            PH5:     raw_bit = code_bit(INVERT, 5);
            default: raw_bit = 1'b0;
        endcase
        bit_o = en ? raw_bit : 1'b0;
    end

    assign phase_o = ph_q;

endmodule

// File: rtl/trail_win_class.sv
module trail_win_class
    import trail_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic [WIN-1:0] win,
    output logic           fwd_hit,
    output logic           rev_hit
);

    logic [PERIOD-1:0] fwd_vec;
    logic [PERIOD-1:0] rev_vec;

    for (genvar g = 0; g < PERIOD; g++) begin : g_win
        localparam logic [WIN-1:0] FWD_W = window_at(INVERT, 1'b0, g);
        localparam logic [WIN-1:0] REV_W = window_at(INVERT, 1'b1, g);
        assign fwd_vec[g] = (win == FWD_W);
        assign rev_vec[g] = (win == REV_W);
    end

    assign fwd_hit = |fwd_vec;
    assign rev_hit = |rev_vec;

endmodule

// File: rtl/trail_dec.sv
module trail_dec
    import trail_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic dir_valid,
    output logic dir_forward,
    output logic dir_err
);

    localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(WIN - 1);

    dec_state_e       st_q;
    dec_state_e       st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [WIN-1:0]   win_q;
    logic             fwd_hit;
    logic             rev_hit;

    // State register, fill count and window
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DS_FILL;
            cnt_q <= '0;
            win_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (in_valid) begin
                win_q <= {win_q[WIN-2:0], in_bit};
            end
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DS_FILL: begin
                if (in_valid) begin
                    if (cnt_q == LAST_FILL) begin
                        st_d  = DS_LIVE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            DS_LIVE: begin
                st_d = DS_LIVE;
            end
            default: begin
                st_d  = DS_FILL;
                cnt_d = '0;
            end
        endcase
    end

    trail_win_class #(.INVERT(INVERT)) u_class (
        .win     (win_q),
        .fwd_hit (fwd_hit),
        .rev_hit (rev_hit)
    );

    // Output logic
    always_comb begin
        dir_valid   = 1'b0;
        dir_forward = 1'b0;
        dir_err     = 1'b0;
        unique case (st_q)
            DS_FILL: begin
                dir_valid = 1'b0;
            end
            DS_LIVE: begin
                dir_valid   = 1'b1;
                dir_forward = fwd_hit;
                dir_err     = !fwd_hit && !rev_hit;
            end
            default: begin
                dir_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/trail_dir_codec.sv
module trail_dir_codec
    import trail_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic gen_en,
    output logic trail_out,
    input  logic in_valid,
    input  logic in_bit,
    output logic dir_valid,
    output logic dir_forward,
    output logic dir_err
);

    logic [PH_W-1:0] gen_phase;

    trail_gen #(.INVERT(INVERT)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .en      (gen_en),
        .bit_o   (trail_out),
        .phase_o (gen_phase)
    );

    trail_dec #(.INVERT(INVERT)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_bit      (in_bit),
        .dir_valid   (dir_valid),
        .dir_forward (dir_forward),
        .dir_err     (dir_err)
    );

endmodule

// File: rtl/trail_dir_chk.sv
module trail_dir_chk
    import trail_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            gen_en,
    input logic            in_valid,
    input logic [PH_W-1:0] gen_phase,
    input logic            trail_out,
    input logic            dir_valid,
    input logic            dir_forward,
    input logic            dir_err
);

    a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (gen_en && gen_phase == PH_W'(PERIOD - 1)) |=> (gen_phase == '0));

    a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> $stable(gen_phase));

    a_r3_quiet_out: assert property (@(posedge clk) disable iff (rst)
        !gen_en |-> !trail_out);

    a_r4_valid_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_valid) |-> $past(in_valid));

    a_r5_fwd_not_err: assert property (@(posedge clk) disable iff (rst)
        dir_forward |-> (dir_valid && !dir_err));

    a_r7_err_gated: assert property (@(posedge clk) disable iff (rst)
        dir_err |-> (dir_valid && !dir_forward));

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!dir_valid && gen_phase == '0));

endmodule

bind trail_dir_codec trail_dir_chk u_chk (.*);

// File: tb/tb_trail_dir_codec.sv
module tb_trail_dir_codec;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gen_en = 1'b0;
    logic in_valid = 1'b0;
    logic drv_bit = 1'b0;
    logic loop_mode = 1'b0;
    logic in_bit;

    logic trail_out, dir_valid, dir_forward, dir_err;
    logic trail_out_i, dir_valid_i, dir_forward_i, dir_err_i;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    // Reference model state
    int phase_m = 0;
    int cnt_m   = 0;
    bit hist_m[$];
    bit pat[6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    logic [4:0] fwd_set[6] = '{5'b10011, 5'b00110, 5'b01101, 5'b11010, 5'b10100, 5'b01001};
    logic [4:0] bwd_set[6] = '{5'b01100, 5'b11001, 5'b10010, 5'b00101, 5'b01011, 5'b10110};

    assign in_bit = loop_mode ? trail_out : drv_bit;

    trail_dir_codec #(.INVERT(1'b0)) dut (
        .clk(clk), .rst(rst), .gen_en(gen_en), .trail_out(trail_out),
        .in_valid(in_valid), .in_bit(in_bit), .dir_valid(dir_valid),
        .dir_forward(dir_forward), .dir_err(dir_err));

    trail_dir_codec #(.INVERT(1'b1)) dut_inv (
        .clk(clk), .rst(rst), .gen_en(gen_en), .trail_out(trail_out_i),
        .in_valid(in_valid), .in_bit(in_bit), .dir_valid(dir_valid_i),
        .dir_forward(dir_forward_i), .dir_err(dir_err_i));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] win_m();
        logic [4:0] w = '0;
        foreach (hist_m[i]) w = {w[3:0], hist_m[i]};
        return w;
    endfunction

    // 1 = in first set, 2 = in second set, 0 = neither
    function automatic int classify(input logic [4:0] w, input bit inv);
        for (int i = 0; i < 6; i++) begin
            if (w == (inv ? bwd_set[i] : fwd_set[i])) return 1;
            if (w == (inv ? fwd_set[i] : bwd_set[i])) return 2;
        end
        return 0;
    endfunction

    function automatic bit exp_bit(input bit inv);
        return gen_en ? (pat[phase_m] ^ inv) : 1'b0;
    endfunction

    // Model update at the active edge (inputs are stable there)
    always @(posedge clk) begin
        bit b;
        b = loop_mode ? exp_bit(1'b0) : drv_bit;
        if (rst) begin
            phase_m = 0;
            cnt_m   = 0;
            hist_m.delete();
        end else begin
            if (gen_en) phase_m = (phase_m + 1) % 6;
            if (in_valid) begin
                hist_m.push_back(b);
                if (hist_m.size() > 5) void'(hist_m.pop_front());
                if (cnt_m < 5) cnt_m++;
            end
        end
    end

    // Comparison every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            string rq;
            int c;
            int ci;
            rq = gen_en ? "R1" : "R3";
            chk(rq, "trail_out", trail_out, exp_bit(1'b0));
            chk(gen_en ? "R2" : "R3", "trail_out_inv", trail_out_i, exp_bit(1'b1));
            // R4 and R9: outputs track the accepted bits from the accepting edge on
            chk("R4", "dir_valid", dir_valid, int'(cnt_m >= 5));
            chk("R4", "dir_valid_inv", dir_valid_i, int'(cnt_m >= 5));
            if (cnt_m >= 5) begin
                c  = classify(win_m(), 1'b0);
                ci = classify(win_m(), 1'b1);
                rq = (c == 1) ? "R5" : (c == 2) ? "R6" : "R7";
                chk(rq, "dir_forward", dir_forward, int'(c == 1));
                chk(rq, "dir_err", dir_err, int'(c == 0));
                rq = (ci == 1) ? "R2" : (ci == 2) ? "R6" : "R7";
                chk(rq, "dir_forward_inv", dir_forward_i, int'(ci == 1));
                chk(rq, "dir_err_inv", dir_err_i, int'(ci == 0));
            end else begin
                chk("R7", "dir_err", dir_err, 0);
                chk("R7", "dir_err_inv", dir_err_i, 0);
            end
        end
    end

    task automatic step(input bit en, input bit v, input bit b);
        gen_en   = en;
        in_valid = v;
        drv_bit  = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: state after reset
        chk("R8", "dir_valid after reset", dir_valid, 0);
        // Generator alone, with stalls (R1, R3)
        for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++)  step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++)  step(1'b1, 1'b0, 1'b0);
        // Loopback with gapped strobe (R4, R5)
        loop_mode = 1'b1;
        for (int i = 0; i < 30; i++) step(1'b1, (i % 4) != 2, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0);
        loop_mode = 1'b0;
        // Backward stream, straddling the switch (R6)
        for (int k = 0; k < 3; k++)
            for (int i = 5; i >= 0; i--) step(1'b0, 1'b1, pat[i]);
        // Foreign patterns (R7)
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, i[0]);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0);
        // Mid-run reset (R8) then refill with strobe gaps (R4)
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b1);
        rst = 1'b0;
        chk("R8", "dir_valid post reset", dir_valid, 0);
        chk("R8", "trail_out phase 0", trail_out, 1);
        for (int i = 0; i < 10; i++) step(1'b1, i[0], pat[i % 6]);
        // Mixed random-ish stream
        for (int i = 0; i < 60; i++) step(i[1] ^ i[3], (i % 3) != 0, i[0] ^ i[2] ^ i[4]);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule